// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame should be taken in, looking only at its 48-bit destination address. A receive path presents the address with a one-cycle strobe, together with the current filter configuration. One clock later the block returns an accept flag, a reason code that says which rule made the decision, and the 6-bit hash it computed for the address.

Four rules apply, in priority order. Promiscuous mode takes every frame. The all-ones broadcast address is governed by its own enable. Any other group address is looked up in a 64-bin table that is held as two 32-bit words, using a 6-bit hash that folds the six address bytes together with fixed shifts and XORs. An individual (unicast) address is rejected unless the mode is promiscuous, because station-address matching is done somewhere else. The table can be loaded with all ones to take every group address.

Top module: `mhf_filter`

## Requirements
- R1: While reset is held and after it is released, out_valid, out_accept, out_reason and out_hash all read 0 until the first strobe.
- R2: A strobe on in_valid produces exactly one out_valid pulse, in the cycle that follows. Back-to-back strobes give back-to-back results, each belonging to its own address.
- R3: Byte k of the address is in_addr[47-8k -: 8], and byte 0 is the first byte on the wire. For each byte b, a term is formed that depends on the byte's position within its three-byte group (bytes 0-2, then bytes 3-5): position 0 gives (b>>2)^(b<<4), position 1 gives (b>>4)^(b<<2), position 2 gives (b>>6)^b. out_hash is the XOR of all six terms, kept to its low 6 bits.
- R4: A hash h below 32 selects bit h of cfg_tbl_lo. A hash from 32 to 63 selects bit h-32 of cfg_tbl_hi.
- R5: With cfg_promisc set, every address is accepted with reason 1.
- R6: The address with all 48 bits set is accepted with reason 2 when cfg_bcast_en is set, and rejected with reason 3 when it is clear. The table plays no part in either case.
- R7: A group address is one whose bit 0 of byte 0 (in_addr[40]) is 1 and that is not the broadcast address. With cfg_mcast_en set, a group address is accepted with reason 4 if its table bit is 1, and rejected with reason 5 if that bit is 0.
- R8: With cfg_mcast_en clear and not promiscuous, a group address is rejected with reason 6 whatever the table holds.
- R9: An address with in_addr[40] equal to 0 is rejected with reason 0 when not promiscuous.
- R10: With both table words set to all ones and cfg_mcast_en set, every group address is accepted.
- R11: In cycles with no strobe, out_accept, out_reason and out_hash keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Address strobe, one cycle per address |
| in_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| cfg_promisc | input | 1 | Accept every address |
| cfg_bcast_en | input | 1 | Allow the broadcast address |
| cfg_mcast_en | input | 1 | Allow group addresses through the hash table |
| cfg_tbl_lo | input | 32 | Hash table bins 0 to 31 |
| cfg_tbl_hi | input | 32 | Hash table bins 32 to 63 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_accept | output | 1 | 1 when the address is accepted |
| out_reason | output | 3 | Rule that decided (codes in R5 to R9) |
| out_hash | output | 6 | Hash of the address |

## Verification
The assertions take the configuration to be steady in every cycle that carries a strobe, because they compare each result against the sampled inputs one cycle earlier. They also expect in_valid to be driven low, not left unknown, during reset. The bench changes configuration and address together, only on falling edges, and keeps all inputs at zero during reset. Its sweeps cover every table bin, both address halves, and every combination of mode bits against each address class.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  localparam int unsigned HASH_W = 6;

  typedef enum logic [2:0] {
    RSN_UCAST_DROP = 3'd0,
    RSN_PROMISC    = 3'd1,
    RSN_BCAST_OK   = 3'd2,
    RSN_BCAST_OFF  = 3'd3,
    RSN_HASH_HIT   = 3'd4,
    RSN_HASH_MISS  = 3'd5,
    RSN_MCAST_OFF  = 3'd6
  } reason_e;

  // Contribution of one address byte, selected by its place inside a group.
  function automatic logic [HASH_W-1:0] lane_term(input logic [7:0] b,
                                                  input int unsigned pos);
    logic [HASH_W-1:0] t;
    case (pos)
      0:       t = HASH_W'((b >> 2) ^ (b << 4));
      1:       t = HASH_W'((b >> 4) ^ (b << 2));
      default: t = HASH_W'((b >> 6) ^ b);
    endcase
    return t;
  endfunction

endpackage

// File: rtl/mhf_hash.sv
module mhf_hash
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES  = 6,
  parameter int unsigned GROUP_BYTES = 3
) (
  input  logic [8*ADDR_BYTES-1:0] addr,
  output logic [HASH_W-1:0]       hash
);
  localparam int unsigned ADDR_W = 8 * ADDR_BYTES;

  logic [HASH_W-1:0] terms [ADDR_BYTES];

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_lane
    assign terms[i] = lane_term(addr[ADDR_W-1-8*i -: 8], i % GROUP_BYTES);
  end

  always_comb begin
    hash = '0;
    for (int i = 0; i < ADDR_BYTES; i++) hash ^= terms[i];
  end
endmodule

// File: rtl/mhf_classify.sv
module mhf_classify #(
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic [8*ADDR_BYTES-1:0] addr,
  output logic                    is_bcast,
  output logic                    is_group
);
  localparam int unsigned ADDR_W = 8 * ADDR_BYTES;
  localparam int unsigned GRP_BIT = ADDR_W - 8;

  assign is_bcast = &addr;
  assign is_group = addr[GRP_BIT];
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
  import mhf_pkg::*;
#(
  parameter int unsigned TBL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              promisc,
  input  logic              bcast_en,
  input  logic              mcast_en,
  input  logic              is_bcast,
  input  logic              is_group,
  input  logic [HASH_W-1:0] hash,
  input  logic [TBL_W-1:0]  tbl_lo,
  input  logic [TBL_W-1:0]  tbl_hi,
  output logic              tbl_hit,
  output logic              res_valid,
  output logic              res_accept,
  output reason_e           res_reason,
  output logic [HASH_W-1:0] res_hash
);
  localparam int unsigned IDX_W = HASH_W - 1;

  logic [IDX_W-1:0] idx;
  logic             nxt_accept;
  reason_e          nxt_reason;

  assign idx = hash[IDX_W-1:0];

  always_comb begin
    if (hash[HASH_W-1]) tbl_hit = tbl_hi[idx];
    else                tbl_hit = tbl_lo[idx];
  end

  always_comb begin
    if (promisc) begin
      nxt_accept = 1'b1; nxt_reason = RSN_PROMISC;
    end else if (is_bcast) begin
      nxt_accept = bcast_en;
      nxt_reason = bcast_en ? RSN_BCAST_OK : RSN_BCAST_OFF;
    end else if (is_group) begin
      if (!mcast_en) begin
        nxt_accept = 1'b0; nxt_reason = RSN_MCAST_OFF;
      end else begin
        nxt_accept = tbl_hit;
        nxt_reason = tbl_hit ? RSN_HASH_HIT : RSN_HASH_MISS;
      end
    end else begin
      nxt_accept = 1'b0; nxt_reason = RSN_UCAST_DROP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_reason <= RSN_UCAST_DROP;
      res_hash   <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_accept <= nxt_accept;
        res_reason <= nxt_reason;
        res_hash   <= hash;
      end
    end
  end

  // Empty table with group filtering on can never accept a group address.
  assert_empty_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !promisc && !is_bcast && is_group && mcast_en &&
     tbl_lo == '0 && tbl_hi == '0) |=> !res_accept);

  assert_full_table_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !promisc && !is_bcast && is_group && mcast_en &&
     (&tbl_lo) && (&tbl_hi)) |=> res_accept);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_hash) && $stable(res_accept) && $stable(res_reason)));
endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES  = 6,
  parameter int unsigned GROUP_BYTES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [47:0] in_addr,
  input  logic        cfg_promisc,
  input  logic        cfg_bcast_en,
  input  logic        cfg_mcast_en,
  input  logic [31:0] cfg_tbl_lo,
  input  logic [31:0] cfg_tbl_hi,
  output logic        out_valid,
  output logic        out_accept,
  output logic [2:0]  out_reason,
  output logic [5:0]  out_hash
);
  localparam int unsigned TBL_W = (1 << HASH_W) / 2;

  logic              ev_bcast;
  logic              ev_group;
  logic              ev_tbl_hit;
  logic [HASH_W-1:0] ev_hash;
  reason_e           res_reason;

  mhf_hash #(.ADDR_BYTES(ADDR_BYTES), .GROUP_BYTES(GROUP_BYTES)) u_hash (
    .addr(in_addr), .hash(ev_hash));

  mhf_classify #(.ADDR_BYTES(ADDR_BYTES)) u_class (
    .addr(in_addr), .is_bcast(ev_bcast), .is_group(ev_group));

  mhf_decide #(.TBL_W(TBL_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .promisc(cfg_promisc), .bcast_en(cfg_bcast_en), .mcast_en(cfg_mcast_en),
    .is_bcast(ev_bcast), .is_group(ev_group), .hash(ev_hash),
    .tbl_lo(cfg_tbl_lo), .tbl_hi(cfg_tbl_hi), .tbl_hit(ev_tbl_hit),
    .res_valid(out_valid), .res_accept(out_accept),
    .res_reason(res_reason), .res_hash(out_hash));

  assign out_reason = res_reason;

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_no_extra_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_promisc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_promisc) |=> (out_accept && out_reason == 3'd1));

  assert_bcast_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_promisc && !cfg_bcast_en && (&in_addr)) |=>
      (!out_accept && out_reason == 3'd3));

  assert_unicast_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_promisc && !in_addr[40]) |=> !out_accept);

  assert_hit_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_promisc && ev_group && !ev_bcast && cfg_mcast_en && !ev_tbl_hit)
      |=> !out_accept);
endmodule

// File: tb/mhf_filter_test.sv
module mhf_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [47:0] in_addr = '0;
  logic        cfg_promisc = 1'b0, cfg_bcast_en = 1'b0, cfg_mcast_en = 1'b0;
  logic [31:0] cfg_tbl_lo = '0, cfg_tbl_hi = '0;
  logic        out_valid, out_accept;
  logic [2:0]  out_reason;
  logic [5:0]  out_hash;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mhf_filter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .cfg_promisc(cfg_promisc), .cfg_bcast_en(cfg_bcast_en),
    .cfg_mcast_en(cfg_mcast_en), .cfg_tbl_lo(cfg_tbl_lo), .cfg_tbl_hi(cfg_tbl_hi),
    .out_valid(out_valid), .out_accept(out_accept),
    .out_reason(out_reason), .out_hash(out_hash));

  function automatic int ref_hash(input logic [47:0] a);
    int h = 0;
    for (int k = 0; k < 6; k++) begin
      int v = int'(a[47-8*k -: 8]);
      case (k % 3)
        0: h = h ^ (v / 4) ^ (v * 16);
        1: h = h ^ (v / 16) ^ (v * 4);
        default: h = h ^ (v / 64) ^ v;
      endcase
    end
    return h % 64;
  endfunction

  function automatic int ref_bit(input int h, input logic [31:0] lo, input logic [31:0] hi);
    if (h < 32) return int'((lo >> h) & 32'd1);
    return int'((hi >> (h - 32)) & 32'd1);
  endfunction

  // returns accept*8 + reason
  function automatic int ref_dec(input logic [47:0] a, input logic p, input logic b,
                                 input logic m, input logic [31:0] lo, input logic [31:0] hi);
    if (p) return 8 + 1;
    if (a == {48{1'b1}}) return b ? 8 + 2 : 3;
    if (a[40]) begin
      if (!m) return 6;
      return ref_bit(ref_hash(a), lo, hi) == 1 ? 8 + 4 : 5;
    end
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setcfg(input logic p, input logic b, input logic m,
                        input logic [31:0] lo, input logic [31:0] hi);
    cfg_promisc = p; cfg_bcast_en = b; cfg_mcast_en = m;
    cfg_tbl_lo = lo; cfg_tbl_hi = hi;
  endtask

  // drive at falling edge, result appears after next rising edge, sampled at the falling edge after
  task automatic send_check(input logic [47:0] a, input string req);
    int d;
    @(negedge clk);
    in_addr = a; in_valid = 1'b1;
    d = ref_dec(a, cfg_promisc, cfg_bcast_en, cfg_mcast_en, cfg_tbl_lo, cfg_tbl_hi);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, {req, " R2 valid"}, int'(out_valid), 1);
    check(int'(out_accept) == d / 8, {req, " accept"}, int'(out_accept), d / 8);
    check(int'(out_reason) == d % 8, {req, " reason"}, int'(out_reason), d % 8);
    check(int'(out_hash) == ref_hash(a), "R3 hash", int'(out_hash), ref_hash(a));
  endtask

  function automatic logic [47:0] sweep_addr(input int i);
    logic [7:0] b0, b1, b2, b3, b4, b5;
    b0 = 8'((i * 37 + 1) | 1); b1 = 8'(i); b2 = 8'(i * 3);
    b3 = 8'(255 - i); b4 = 8'(i * 7); b5 = 8'(i ^ 8'h5a);
    return {b0, b1, b2, b3, b4, b5};
  endfunction

  initial begin : watchdog
    #400000;
    n_fail++; n_checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [47:0] a;
    logic [47:0] types [4];
    logic [31:0] onehot_lo, onehot_hi;
    int base, d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 0, "R1 valid", int'(out_valid), 0);
    check(out_accept == 0, "R1 accept", int'(out_accept), 0);
    check(out_reason == 0, "R1 reason", int'(out_reason), 0);
    check(out_hash == 0, "R1 hash", int'(out_hash), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 0 && out_hash == 0, "R1 after release", int'(out_hash), 0);

    // R3 R7: hash and table lookup over many address patterns
    setcfg(0, 1, 1, 32'hA5C3_0F96, 32'h3C69_E11B);
    for (int i = 0; i < 256; i++) send_check(sweep_addr(i), "R7 sweep");

    // R4: every bin, set alone and cleared alone; b5 term is linear in its low 6 bits
    base = ref_hash({8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'h00});
    for (int bin = 0; bin < 64; bin++) begin
      a = {8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'(bin ^ base)};
      onehot_lo = (bin < 32) ? (32'd1 << bin) : 32'd0;
      onehot_hi = (bin >= 32) ? (32'd1 << (bin - 32)) : 32'd0;
      setcfg(0, 1, 1, onehot_lo, onehot_hi);
      send_check(a, "R4 bin set");
      check(out_accept == 1'b1, "R4 hit", int'(out_accept), 1);
      setcfg(0, 1, 1, ~onehot_lo, ~onehot_hi);
      send_check(a, "R4 bin clear");
      check(out_accept == 1'b0, "R4 miss", int'(out_accept), 0);
    end

    // R5 R6 R8 R9: every mode combination against each address class
    types[0] = 48'h0211_2233_4455;            // unicast
    types[1] = {48{1'b1}};                    // broadcast
    types[2] = 48'h0100_5E00_00FB;            // group address
    types[3] = 48'h3333_0000_0001;            // group address
    for (int mode = 0; mode < 8; mode++) begin
      for (int t = 0; t < 4; t++) begin
        for (int tb = 0; tb < 2; tb++) begin
          setcfg(mode[2], mode[1], mode[0], tb ? 32'hFFFF_FFFF : 32'h0,
                 tb ? 32'h0 : 32'hFFFF_FFFF);
          send_check(types[t], "R5 R6 R8 R9 modes");
        end
      end
    end

    // R10: all-ones table accepts every group address
    setcfg(0, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int i = 0; i < 64; i++) begin
      send_check(sweep_addr(i * 3 + 1), "R10 all ones");
      check(out_accept == 1'b1 || sweep_addr(i * 3 + 1) == {48{1'b1}},
            "R10 accept", int'(out_accept), 1);
    end

    // R11 and R2: outputs hold with no strobe, single pulse only
    setcfg(0, 1, 1, 32'h0000_0001, 32'h8000_0000);
    a = 48'h0300_1234_ABCD;
    send_check(a, "R11 setup");
    d = ref_dec(a, 0, 1, 1, 32'h0000_0001, 32'h8000_0000);
    in_addr = 48'h0000_0000_0000;
    setcfg(1, 0, 0, 32'h0, 32'h0);
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 0, "R2 single pulse", int'(out_valid), 0);
      check(int'(out_accept) == d / 8 && int'(out_reason) == d % 8,
            "R11 hold decision", int'(out_reason), d % 8);
      check(int'(out_hash) == ref_hash(a), "R11 hold hash", int'(out_hash), ref_hash(a));
    end

    // R2: back-to-back strobes
    setcfg(0, 1, 1, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    @(negedge clk);
    in_valid = 1'b1; in_addr = sweep_addr(11);
    @(negedge clk);
    in_addr = sweep_addr(12);
    check(out_valid == 1 && int'(out_hash) == ref_hash(sweep_addr(11)),
          "R2 first of pair", int'(out_hash), ref_hash(sweep_addr(11)));
    @(negedge clk);
    in_valid = 1'b0;
    d = ref_dec(sweep_addr(12), 0, 1, 1, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    check(out_valid == 1 && int'(out_hash) == ref_hash(sweep_addr(12)),
          "R2 second of pair", int'(out_hash), ref_hash(sweep_addr(12)));
    check(int'(out_reason) == d % 8, "R2 second reason", int'(out_reason), d % 8);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule